// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches page-table entries so that a 32-bit virtual address can be turned into a physical address without walking the tables in memory. Pages are 4 KB. The cache holds 16 sets of 4 ways, and each way stores a valid bit, a kind flag, a 16-bit tag and the 32-bit table entry. A way is either a leaf entry, which maps one page, or a directory entry, which stands for a whole page-table page. A lookup that misses on the leaf can still return a directory entry, so the table walker that follows only has to fetch the last level.

A lookup is presented for one cycle. The hit flags, the cached entry and the formed physical address appear on registered outputs one cycle later. A fill port writes one entry after a walk completes. A context-flush input clears every entry that is not marked global in the same cycle. Within a set, ways that are not in use are filled first. When all four ways are in use, a 3-bit pseudo-LRU tree chooses the way to replace. The tree is updated on every lookup hit and on every fill.

Top module: `xlate_cache`

## Requirements
- R1: The set index is vaddr[15:12] and the tag is vaddr[31:16]. A lookup with `lk_valid` high gives `rsp_valid` high on the next cycle. `rsp_leaf_hit` is high when a valid leaf entry in that set holds the same tag.
- R2: On a leaf hit, `rsp_entry` is the stored entry and `rsp_paddr` is {entry[31:12], vaddr[11:0]}. Without a leaf hit, `rsp_paddr` is zero.
- R3: An entry filled with `fill_dir`=1 matches a lookup in the same set whose vaddr[31:22] equals bits 15:6 of the stored tag, and it raises `rsp_dir_hit`. Leaf and directory hits are reported independently. `rsp_entry` shows the leaf entry when there is a leaf hit, and the directory entry when there is only a directory hit.
- R4: A fill whose entry has bit 0 (present) clear writes nothing.
- R5: A fill whose address and kind match an entry already in the set overwrites that way, so no duplicate is created.
- R6: A fill into a set with an unused way takes the lowest-numbered unused way.
- R7: In a full set, the victim follows a 3-bit tree. The root selects ways 0/1 when it is 0 and ways 2/3 when it is 1. The pair bit then selects the higher way when it is 1. A hit or fill on a way points the tree away from that way.
- R8: A pulse on `flush_ctx` invalidates every entry whose bit 8 (global) is 0. Entries with bit 8 set still hit afterwards.
- R9: A lookup in the same cycle as an accepted fill to the same set reports no hit of either kind, and the fill still takes effect.
- R10: After reset, every entry is invalid and all response outputs are zero.
- R11: A cycle without `lk_valid` gives `rsp_valid`, `rsp_leaf_hit` and `rsp_dir_hit` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| fill_en | input | 1 | Fill request this cycle |
| fill_vaddr | input | 32 | Virtual address the fill belongs to |
| fill_dir | input | 1 | 1: directory entry, 0: leaf entry |
| fill_entry | input | 32 | Table entry to store |
| flush_ctx | input | 1 | Invalidate all non-global entries |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_leaf_hit | output | 1 | Leaf entry found |
| rsp_dir_hit | output | 1 | Directory entry found |
| rsp_entry | output | 32 | Cached entry that hit |
| rsp_paddr | output | 32 | Physical address on a leaf hit |

## Verification
Every lookup result is due on the registered outputs exactly one rising edge after the request. A fill or a flush changes the stored state on the rising edge that samples it, so a lookup sent in the next cycle already sees the change. The bench changes inputs on falling edges and reads the response at the next falling edge. Each sample therefore falls half a cycle after the edge that produced it. Replacement checks count every lookup hit as a tree update and predict the victim from that sequence.

// File: rtl/xc_pkg.sv
package xc_pkg;

    localparam int XC_WAYS  = 4;
    localparam int XC_WAY_W = 2;

    typedef enum logic [1:0] {
        FILL_SAME   = 2'd0,
        FILL_FREE   = 2'd1,
        FILL_VICTIM = 2'd2
    } fill_src_e;

    // tree bits: [0] root, [1] pair of ways 0/1, [2] pair of ways 2/3
    function automatic logic [XC_WAY_W-1:0] plru_pick(input logic [2:0] t);
        if (!t[0])
            return t[1] ? 2'd1 : 2'd0;
        else
            return t[2] ? 2'd3 : 2'd2;
    endfunction

    function automatic logic [2:0] plru_touch(input logic [2:0] t,
                                              input logic [XC_WAY_W-1:0] w);
        logic [2:0] n;
        n = t;
        unique case (w)
            2'd0: begin n[0] = 1'b1; n[1] = 1'b1; end
            2'd1: begin n[0] = 1'b1; n[1] = 1'b0; end
            2'd2: begin n[0] = 1'b0; n[2] = 1'b1; end
            2'd3: begin n[0] = 1'b0; n[2] = 1'b0; end
        endcase
        return n;
    endfunction

    function automatic logic [XC_WAY_W-1:0] lowest_way(input logic [XC_WAYS-1:0] v);
        logic [XC_WAY_W-1:0] r;
        r = '0;
        for (int i = XC_WAYS - 1; i >= 0; i--)
            if (v[i]) r = XC_WAY_W'(i);
        return r;
    endfunction

endpackage

// File: rtl/xc_entry_store.sv
module xc_entry_store
    import xc_pkg::*;
#(
    parameter int SETS       = 16,
    parameter int IDX_W      = $clog2(SETS),
    parameter int TAG_W      = 16,
    parameter int PTE_W      = 32,
    parameter int GLOBAL_BIT = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               flush,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [XC_WAY_W-1:0]                wr_way,
    input  logic                               wr_dir,
    input  logic [TAG_W-1:0]                   wr_tag,
    input  logic [PTE_W-1:0]                   wr_pte,
    input  logic [IDX_W-1:0]                   a_idx,
    input  logic [IDX_W-1:0]                   b_idx,
    output logic [XC_WAYS-1:0]                 a_valid,
    output logic [XC_WAYS-1:0]                 a_dir,
    output logic [XC_WAYS-1:0][TAG_W-1:0]      a_tag,
    output logic [XC_WAYS-1:0][PTE_W-1:0]      a_pte,
    output logic [XC_WAYS-1:0]                 b_valid,
    output logic [XC_WAYS-1:0]                 b_dir,
    output logic [XC_WAYS-1:0][TAG_W-1:0]      b_tag
);

    logic [XC_WAYS-1:0]            valid_q [SETS];
    logic [XC_WAYS-1:0]            dir_q   [SETS];
    logic [XC_WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [XC_WAYS-1:0][PTE_W-1:0] pte_q   [SETS];

    // valid bits: flush first, a same-cycle write then wins for its way
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                valid_q[s] <= '0;
        end else begin
            if (flush) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < XC_WAYS; w++)
                        if (!pte_q[s][w][GLOBAL_BIT])
                            valid_q[s][w] <= 1'b0;
            end
            if (wr_en)
                valid_q[wr_idx][wr_way] <= 1'b1;
        end
    end

    // payload needs no reset: it is qualified by the valid bit
    always_ff @(posedge clk) begin
        if (wr_en) begin
            dir_q[wr_idx][wr_way] <= wr_dir;
            tag_q[wr_idx][wr_way] <= wr_tag;
            pte_q[wr_idx][wr_way] <= wr_pte;
        end
    end

    always_comb begin
        a_valid = valid_q[a_idx];
        a_dir   = dir_q[a_idx];
        a_tag   = tag_q[a_idx];
        a_pte   = pte_q[a_idx];
        b_valid = valid_q[b_idx];
        b_dir   = dir_q[b_idx];
        b_tag   = tag_q[b_idx];
    end

endmodule

// File: rtl/xc_way_match.sv
module xc_way_match
    import xc_pkg::*;
#(
    parameter int TAG_W = 16,
    parameter int DIR_W = 10
) (
    input  logic [XC_WAYS-1:0]            valid,
    input  logic [XC_WAYS-1:0]            dir,
    input  logic [XC_WAYS-1:0][TAG_W-1:0] tag,
    input  logic [TAG_W-1:0]              key,
    output logic [XC_WAYS-1:0]            leaf_vec,
    output logic [XC_WAYS-1:0]            dir_vec
);

    for (genvar w = 0; w < XC_WAYS; w++) begin : g_way
        logic full_eq;
        logic upper_eq;
        assign full_eq     = (tag[w] == key);
        assign upper_eq    = (tag[w][TAG_W-1 -: DIR_W] == key[TAG_W-1 -: DIR_W]);
        assign leaf_vec[w] = valid[w] & ~dir[w] & full_eq;
        assign dir_vec[w]  = valid[w] &  dir[w] & upper_eq;
    end

endmodule

// File: rtl/xc_plru_bank.sv
module xc_plru_bank
    import xc_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit_touch,
    input  logic [IDX_W-1:0]    hit_idx,
    input  logic [XC_WAY_W-1:0] hit_way,
    input  logic                fill_touch,
    input  logic [IDX_W-1:0]    fill_idx,
    input  logic [XC_WAY_W-1:0] fill_way,
    output logic [XC_WAY_W-1:0] victim_way
);

    logic [2:0] tree_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                tree_q[s] <= '0;
        end else begin
            if (hit_touch)
                tree_q[hit_idx] <= plru_touch(tree_q[hit_idx], hit_way);
            if (fill_touch)
                tree_q[fill_idx] <= plru_touch(tree_q[fill_idx], fill_way);
        end
    end

    assign victim_way = plru_pick(tree_q[fill_idx]);

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import xc_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int OFF_W       = 12,
    parameter int SETS        = 16,
    parameter int DIR_W       = 10,
    parameter int PTE_W       = 32,
    parameter int GLOBAL_BIT  = 8,
    parameter int PRESENT_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             fill_en,
    input  logic [VA_W-1:0]  fill_vaddr,
    input  logic             fill_dir,
    input  logic [PTE_W-1:0] fill_entry,
    input  logic             flush_ctx,
    output logic             rsp_valid,
    output logic             rsp_leaf_hit,
    output logic             rsp_dir_hit,
    output logic [PTE_W-1:0] rsp_entry,
    output logic [PTE_W-1:0] rsp_paddr
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;

    logic [IDX_W-1:0] lk_idx, fl_idx;
    logic [TAG_W-1:0] lk_tag, fl_tag;

    assign lk_idx = lk_vaddr[OFF_W +: IDX_W];
    assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
    assign fl_idx = fill_vaddr[OFF_W +: IDX_W];
    assign fl_tag = fill_vaddr[VA_W-1 -: TAG_W];

    // fill acceptance and same-set conflict
    logic fill_take, set_clash, lk_go;
    assign fill_take = fill_en & fill_entry[PRESENT_BIT];
    assign set_clash = fill_take & lk_valid & (fl_idx == lk_idx);
    assign lk_go     = lk_valid & ~set_clash;

    logic [XC_WAYS-1:0]            a_valid, a_dir, b_valid, b_dir;
    logic [XC_WAYS-1:0][TAG_W-1:0] a_tag, b_tag;
    logic [XC_WAYS-1:0][PTE_W-1:0] a_pte;
    logic [XC_WAY_W-1:0]           wr_way, victim_way;

    xc_entry_store #(
        .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .PTE_W(PTE_W), .GLOBAL_BIT(GLOBAL_BIT)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush_ctx),
        .wr_en(fill_take), .wr_idx(fl_idx), .wr_way(wr_way),
        .wr_dir(fill_dir), .wr_tag(fl_tag), .wr_pte(fill_entry),
        .a_idx(lk_idx), .b_idx(fl_idx),
        .a_valid(a_valid), .a_dir(a_dir), .a_tag(a_tag), .a_pte(a_pte),
        .b_valid(b_valid), .b_dir(b_dir), .b_tag(b_tag)
    );

    logic [XC_WAYS-1:0] a_leaf_vec, a_dir_vec, b_leaf_vec, b_dir_vec;

    xc_way_match #(.TAG_W(TAG_W), .DIR_W(DIR_W)) u_match_lk (
        .valid(a_valid), .dir(a_dir), .tag(a_tag), .key(lk_tag),
        .leaf_vec(a_leaf_vec), .dir_vec(a_dir_vec)
    );

    xc_way_match #(.TAG_W(TAG_W), .DIR_W(DIR_W)) u_match_fl (
        .valid(b_valid), .dir(b_dir), .tag(b_tag), .key(fl_tag),
        .leaf_vec(b_leaf_vec), .dir_vec(b_dir_vec)
    );

    // lookup hit resolution
    logic [XC_WAYS-1:0]  leaf_v, dir_v;
    logic                leaf_any, dir_any;
    logic [XC_WAY_W-1:0] leaf_way, dir_way, hit_way;

    assign leaf_v   = a_leaf_vec & {XC_WAYS{lk_go}};
    assign dir_v    = a_dir_vec  & {XC_WAYS{lk_go}};
    assign leaf_any = |leaf_v;
    assign dir_any  = |dir_v;
    assign leaf_way = lowest_way(leaf_v);
    assign dir_way  = lowest_way(dir_v);
    assign hit_way  = leaf_any ? leaf_way : dir_way;

    // fill way selection
    logic [XC_WAYS-1:0] same_vec, free_vec;
    fill_src_e          fill_src;

    assign same_vec = fill_dir ? b_dir_vec : b_leaf_vec;
    assign free_vec = ~b_valid;

    always_comb begin
        if (|same_vec)
            fill_src = FILL_SAME;
        else if (|free_vec)
            fill_src = FILL_FREE;
        else
            fill_src = FILL_VICTIM;
        unique case (fill_src)
            FILL_SAME:   wr_way = lowest_way(same_vec);
            FILL_FREE:   wr_way = lowest_way(free_vec);
            default:     wr_way = victim_way;
        endcase
    end

    xc_plru_bank #(.SETS(SETS), .IDX_W(IDX_W)) u_plru (
        .clk(clk), .rst_n(rst_n),
        .hit_touch(leaf_any | dir_any), .hit_idx(lk_idx), .hit_way(hit_way),
        .fill_touch(fill_take), .fill_idx(fl_idx), .fill_way(wr_way),
        .victim_way(victim_way)
    );

    // response register
    logic [PTE_W-1:0] entry_d, paddr_d;

    always_comb begin
        entry_d = '0;
        paddr_d = '0;
        if (leaf_any) begin
            entry_d = a_pte[leaf_way];
            paddr_d = {a_pte[leaf_way][PTE_W-1:OFF_W], lk_vaddr[OFF_W-1:0]};
        end else if (dir_any) begin
            entry_d = a_pte[dir_way];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_leaf_hit <= 1'b0;
            rsp_dir_hit  <= 1'b0;
            rsp_entry    <= '0;
            rsp_paddr    <= '0;
        end else begin
            rsp_valid    <= lk_valid;
            rsp_leaf_hit <= leaf_any;
            rsp_dir_hit  <= dir_any;
            rsp_entry    <= entry_d;
            rsp_paddr    <= paddr_d;
        end
    end

endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
    parameter int VA_W        = 32,
    parameter int OFF_W       = 12,
    parameter int SETS        = 16,
    parameter int PTE_W       = 32,
    parameter int PRESENT_BIT = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             fill_en,
    input logic [VA_W-1:0]  fill_vaddr,
    input logic [PTE_W-1:0] fill_entry,
    input logic             rsp_valid,
    input logic             rsp_leaf_hit,
    input logic             rsp_dir_hit,
    input logic [PTE_W-1:0] rsp_entry,
    input logic [PTE_W-1:0] rsp_paddr
);

    localparam int IDX_W = $clog2(SETS);

    logic same_set_fill;
    assign same_set_fill = fill_en && fill_entry[PRESENT_BIT] && lk_valid &&
                           (fill_vaddr[OFF_W +: IDX_W] == lk_vaddr[OFF_W +: IDX_W]);

    assert_rsp_due_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_leaf_hit && !rsp_dir_hit));

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_leaf_hit |-> (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    assert_miss_zero_paddr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_leaf_hit |-> (rsp_paddr == '0));

    assert_only_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_leaf_hit || rsp_dir_hit) |-> rsp_entry[PRESENT_BIT]);

    assert_fill_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        same_set_fill |=> (!rsp_leaf_hit && !rsp_dir_hit));

endmodule

bind xlate_cache xlate_cache_chk #(
    .VA_W(VA_W), .OFF_W(OFF_W), .SETS(SETS), .PTE_W(PTE_W), .PRESENT_BIT(PRESENT_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .fill_en(fill_en), .fill_vaddr(fill_vaddr), .fill_entry(fill_entry),
    .rsp_valid(rsp_valid), .rsp_leaf_hit(rsp_leaf_hit), .rsp_dir_hit(rsp_dir_hit),
    .rsp_entry(rsp_entry), .rsp_paddr(rsp_paddr)
);

// File: tb/sim_xlate_cache.sv
`timescale 1ns/1ps
module sim_xlate_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        fill_en = 1'b0;
    logic [31:0] fill_vaddr = '0;
    logic        fill_dir = 1'b0;
    logic [31:0] fill_entry = '0;
    logic        flush_ctx = 1'b0;
    logic        rsp_valid, rsp_leaf_hit, rsp_dir_hit;
    logic [31:0] rsp_entry, rsp_paddr;

    int n_checks = 0;
    int n_errors = 0;

    logic        r_valid, r_leaf, r_dir;
    logic [31:0] r_entry, r_paddr;

    always #2 clk = ~clk;

    xlate_cache u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .fill_en(fill_en), .fill_vaddr(fill_vaddr), .fill_dir(fill_dir),
        .fill_entry(fill_entry), .flush_ctx(flush_ctx),
        .rsp_valid(rsp_valid), .rsp_leaf_hit(rsp_leaf_hit), .rsp_dir_hit(rsp_dir_hit),
        .rsp_entry(rsp_entry), .rsp_paddr(rsp_paddr)
    );

    task automatic expect_eq(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic capture();
        r_valid = rsp_valid;
        r_leaf  = rsp_leaf_hit;
        r_dir   = rsp_dir_hit;
        r_entry = rsp_entry;
        r_paddr = rsp_paddr;
    endtask

    // all tasks start and end on a falling edge
    task automatic fill(input logic [31:0] va, input logic dir, input logic [31:0] pte);
        fill_en = 1'b1; fill_vaddr = va; fill_dir = dir; fill_entry = pte;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va);
        lk_valid = 1'b1; lk_vaddr = va;
        @(negedge clk);
        capture();
        lk_valid = 1'b0;
    endtask

    task automatic look_with_fill(input logic [31:0] va, input logic [31:0] fva,
                                  input logic [31:0] pte);
        lk_valid = 1'b1; lk_vaddr = va;
        fill_en = 1'b1; fill_vaddr = fva; fill_dir = 1'b0; fill_entry = pte;
        @(negedge clk);
        capture();
        lk_valid = 1'b0; fill_en = 1'b0;
    endtask

    task automatic expect_leaf(input string req, input logic [31:0] va, input logic [31:0] pte);
        look(va);
        expect_eq(req, "rsp_valid", 32'(r_valid), 32'd1);
        expect_eq(req, "leaf_hit", 32'(r_leaf), 32'd1);
        expect_eq(req, "entry", r_entry, pte);
        expect_eq(req, "paddr", r_paddr, {pte[31:12], va[11:0]});
    endtask

    task automatic expect_miss(input string req, input logic [31:0] va);
        look(va);
        expect_eq(req, "leaf_hit", 32'(r_leaf), 32'd0);
        expect_eq(req, "dir_hit", 32'(r_dir), 32'd0);
        expect_eq(req, "paddr", r_paddr, 32'd0);
    endtask

    task automatic t_reset();   // R10
        expect_eq("R10", "rsp_valid", 32'(rsp_valid), 32'd0);
        expect_eq("R10", "rsp_entry", rsp_entry, 32'd0);
        expect_eq("R10", "rsp_paddr", rsp_paddr, 32'd0);
        expect_miss("R10", 32'h0000_0000);
        expect_miss("R10", 32'h1234_5678);
    endtask

    task automatic t_leaf();    // R1 R2 R11
        fill(32'h1234_5000, 1'b0, 32'hABCD_E003);
        expect_leaf("R1", 32'h1234_5678, 32'hABCD_E003);
        expect_eq("R2", "paddr", r_paddr, 32'hABCD_E678);
        expect_miss("R1", 32'h2234_5678);
        expect_miss("R1", 32'h1235_5678);
        @(negedge clk);
        expect_eq("R11", "rsp_valid", 32'(rsp_valid), 32'd0);
        expect_eq("R11", "leaf_hit", 32'(rsp_leaf_hit), 32'd0);
    endtask

    task automatic t_dir();     // R3
        fill(32'h4000_0000, 1'b1, 32'h0077_7007);
        look(32'h403F_0123);
        expect_eq("R3", "dir_hit", 32'(r_dir), 32'd1);
        expect_eq("R3", "leaf_hit", 32'(r_leaf), 32'd0);
        expect_eq("R3", "entry", r_entry, 32'h0077_7007);
        expect_eq("R3", "paddr", r_paddr, 32'd0);
        expect_miss("R3", 32'h4040_0000);
        fill(32'h4001_0000, 1'b0, 32'h1111_1001);
        look(32'h4001_0ABC);
        expect_eq("R3", "both dir_hit", 32'(r_dir), 32'd1);
        expect_eq("R3", "both leaf_hit", 32'(r_leaf), 32'd1);
        expect_eq("R3", "both entry", r_entry, 32'h1111_1001);
        expect_eq("R3", "both paddr", r_paddr, 32'h1111_1ABC);
    endtask

    task automatic t_absent();  // R4
        fill(32'h5000_6000, 1'b0, 32'h9999_9000);
        expect_miss("R4", 32'h5000_6000);
    endtask

    task automatic t_update();  // R5
        fill(32'h7000_9000, 1'b0, 32'h4444_4001);
        fill(32'h7000_9000, 1'b0, 32'h5555_5001);
        fill(32'h7100_9000, 1'b0, 32'h0000_1001);
        fill(32'h7200_9000, 1'b0, 32'h0000_2001);
        fill(32'h7300_9000, 1'b0, 32'h0000_3001);
        expect_leaf("R5", 32'h7000_9010, 32'h5555_5001);
        expect_leaf("R5", 32'h7100_9000, 32'h0000_1001);
        expect_leaf("R5", 32'h7200_9000, 32'h0000_2001);
        expect_leaf("R5", 32'h7300_9000, 32'h0000_3001);
    endtask

    task automatic t_plru();    // R6 R7
        for (int i = 0; i < 4; i++)
            fill({16'h8000 + 16'(i), 4'hA, 12'h000}, 1'b0, {20'h0A000 + 20'(i), 12'h001});
        // tree now points at way 0 (first filled)
        fill({16'h8004, 4'hA, 12'h000}, 1'b0, 32'h0A004_001);
        expect_leaf("R7", {16'h8001, 4'hA, 12'h004}, 32'h0A001_001);
        expect_leaf("R7", {16'h8002, 4'hA, 12'h008}, 32'h0A002_001);
        expect_leaf("R7", {16'h8003, 4'hA, 12'h00C}, 32'h0A003_001);
        expect_leaf("R7", {16'h8004, 4'hA, 12'h010}, 32'h0A004_001);
        expect_miss("R7", {16'h8000, 4'hA, 12'h000});
        // hits on 1,2,3,0 leave the tree pointing at way 2
        fill({16'h8005, 4'hA, 12'h000}, 1'b0, 32'h0A005_001);
        expect_miss("R7", {16'h8002, 4'hA, 12'h000});
        expect_leaf("R7", {16'h8005, 4'hA, 12'h000}, 32'h0A005_001);
        expect_leaf("R6", {16'h8001, 4'hA, 12'h000}, 32'h0A001_001);
    endtask

    task automatic t_clash();   // R9
        fill(32'h9000_D000, 1'b0, 32'h6666_6001);
        look_with_fill(32'h9000_D123, 32'h9100_D000, 32'h7777_7001);
        expect_eq("R9", "leaf_hit", 32'(r_leaf), 32'd0);
        expect_eq("R9", "dir_hit", 32'(r_dir), 32'd0);
        expect_leaf("R9", 32'h9100_D000, 32'h7777_7001);
        look_with_fill(32'h9000_D123, 32'h9200_E000, 32'h1212_1001);
        expect_eq("R9", "other set leaf_hit", 32'(r_leaf), 32'd1);
        look_with_fill(32'h9000_D123, 32'h9300_D000, 32'h0000_0000);
        expect_eq("R9", "absent fill leaf_hit", 32'(r_leaf), 32'd1);
    endtask

    task automatic t_flush();   // R8
        fill(32'h6000_7000, 1'b0, 32'h2222_2101);
        fill(32'h6100_7000, 1'b0, 32'h3333_3001);
        flush_ctx = 1'b1;
        @(negedge clk);
        flush_ctx = 1'b0;
        expect_leaf("R8", 32'h6000_7444, 32'h2222_2101);
        expect_miss("R8", 32'h6100_7444);
        expect_miss("R8", 32'h403F_0123);
        expect_miss("R8", 32'h1234_5678);
    endtask

    task automatic t_free_first();  // R6
        fill(32'hA000_C000, 1'b0, 32'h0AAA_A101);
        fill(32'hA001_C000, 1'b0, 32'h0BBB_B001);
        fill(32'hA002_C000, 1'b0, 32'h0CCC_C001);
        fill(32'hA003_C000, 1'b0, 32'h0DDD_D001);
        flush_ctx = 1'b1;
        @(negedge clk);
        flush_ctx = 1'b0;
        // tree would pick way 0; an unused way must be taken instead
        fill(32'hA004_C000, 1'b0, 32'h0EEE_E001);
        expect_leaf("R6", 32'hA000_C000, 32'h0AAA_A101);
        expect_leaf("R6", 32'hA004_C000, 32'h0EEE_E001);
        expect_miss("R6", 32'hA001_C000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_leaf();
        t_dir();
        t_absent();
        t_update();
        t_plru();
        t_clash();
        t_flush();
        t_free_first();
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog run did not complete");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule